// File: doc/BRIEF.md
# Fault Flag and Slope-Select Latch

This block controls a bidirectional pin that carries two signals at different times. When the battery supply comes up, the block keeps the pin's output driver off and reads the pin level once. That level picks one of two slew profiles for the bus driver, and the choice is held until the battery goes away.

For the rest of the time the block drives the same pin as an active-low fault flag. The flag goes low when the transmit data differs from the level read back from the bus. A thermal-overload indication forces it low at all times. Every edge on transmit data briefly makes the transmitted and received levels disagree while the bus moves, so a counter blanks the mismatch test for a set number of cycles after each such edge.

Transmit data, received data and the pin input are synchronised into the clock domain before use. The thermal, battery and regulator flags are already synchronous.

Top module: `fault_slope_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, `pin_oe_o` is 0 and `slope_fast_o` is 0 (normal slope).
- R2: `pin_oe_o` stays 0 and no sample is taken while either `bat_ok_i` or `vreg_ok_i` is low and the block has not yet sampled.
- R3: On the first clock edge where `bat_ok_i` and `vreg_ok_i` are both high, the synchronised pin level is captured: 1 gives `slope_fast_o`=0 (normal), 0 gives `slope_fast_o`=1 (alternate, faster). `pin_oe_o` becomes 1 at that same edge.
- R4: Once sampled, the slope selection and `pin_oe_o`=1 hold however `vreg_ok_i` and `pin_i` later change, for as long as `bat_ok_i` stays high.
- R5: `bat_ok_i` low clears the slope to normal and drops `pin_oe_o` on the next edge. The next rise of both flags samples the pin again.
- R6: With `therm_i` low and no blanking active, `pin_o` is 1 when the synchronised TXD and RXD are equal and 0 when they differ. After a change on `rxd_i` alone, `pin_o` follows at the (SYNC_STAGES+1)-th clock edge.
- R7: `therm_i` high forces `pin_o` to 0 at the next clock edge, whatever the TXD and RXD levels and whether blanking is active.
- R8: A TXD edge blanks the mismatch test for MASK_CYC evaluation cycles. A persistent mismatch created by a TXD edge therefore reaches `pin_o` at the (MASK_CYC+SYNC_STAGES+1)-th edge after `txd_i` changes, and not before.
- R9: A further TXD edge inside the blanking window restarts the window from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txd_i | input | 1 | Transmit data from the controller |
| rxd_i | input | 1 | Bus level as received |
| therm_i | input | 1 | Thermal overload flag, synchronous |
| bat_ok_i | input | 1 | Battery risen and stable; low means battery off |
| vreg_ok_i | input | 1 | Regulator output within its valid band |
| pin_i | input | 1 | Level read from the shared pin |
| pin_o | output | 1 | Fault flag driven onto the pin, 0 = fault |
| pin_oe_o | output | 1 | Output enable for the shared pin |
| slope_fast_o | output | 1 | Latched slope mode, 1 = alternate fast slope |

## Verification
The thermal override is due one edge after `therm_i` changes. A change on RXD alone takes SYNC_STAGES+1 edges. A mismatch created by a TXD edge becomes visible only at edge MASK_CYC+SYNC_STAGES+1. The slope latch and the output enable update on the edge that sees the qualifying flags. The bench drives every input on a falling edge, counts rising edges from that point, and samples one time unit after the edge at which each result is due. For the latency cases it also samples one edge earlier, which shows that the result does not come early.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_RUN  = 1'b1
  } pin_state_e;

  typedef enum logic {
    SLOPE_NORMAL = 1'b0,
    SLOPE_FAST   = 1'b1
  } slope_e;
endpackage

// File: rtl/fsl_sync.sv
module fsl_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/fsl_slope_latch.sv
module fsl_slope_latch
  import fsl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   bat_ok_i,
  input  logic   vreg_ok_i,
  input  logic   pin_s_i,
  output logic   oe_o,
  output slope_e slope_o
);
  pin_state_e state_q;
  slope_e     slope_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      slope_q <= SLOPE_NORMAL;
    end else if (!bat_ok_i) begin
      // battery lost: forget selection, re-arm
      state_q <= ST_WAIT;
      slope_q <= SLOPE_NORMAL;
    end else begin
      unique case (state_q)
        ST_WAIT: if (vreg_ok_i) begin
          slope_q <= pin_s_i ? SLOPE_NORMAL : SLOPE_FAST;
          state_q <= ST_RUN;
        end
        ST_RUN: ;
        default: state_q <= ST_WAIT;
      endcase
    end
  end

  assign oe_o    = (state_q == ST_RUN);
  assign slope_o = slope_q;
endmodule

// File: rtl/fsl_fault_eval.sv
module fsl_fault_eval #(
  parameter int unsigned MASK_CYC = 600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_s_i,
  input  logic rxd_s_i,
  input  logic therm_i,
  output logic ok_o
);
  localparam int unsigned CW = (MASK_CYC > 0) ? $clog2(MASK_CYC + 1) : 1;

  logic txd_d;
  logic tx_edge;
  logic masked;
  logic mismatch;
  logic ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) txd_d <= 1'b1;
    else         txd_d <= txd_s_i;
  end

  assign tx_edge  = txd_s_i ^ txd_d;
  assign mismatch = txd_s_i ^ rxd_s_i;

  generate
    if (MASK_CYC == 0) begin : g_nomask
      assign masked = 1'b0;
    end else begin : g_mask
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           cnt_q <= '0;
        else if (tx_edge)      cnt_q <= CW'(MASK_CYC - 1);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      end
      assign masked = tx_edge | (cnt_q != '0);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ok_q <= 1'b1;
    else         ok_q <= !(therm_i | (mismatch & !masked));
  end

  assign ok_o = ok_q;
endmodule

// File: rtl/fault_slope_ctrl.sv
module fault_slope_ctrl
  import fsl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MASK_CYC    = 600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  input  logic rxd_i,
  input  logic therm_i,
  input  logic bat_ok_i,
  input  logic vreg_ok_i,
  input  logic pin_i,
  output logic pin_o,
  output logic pin_oe_o,
  output logic slope_fast_o
);
  logic [2:0] raw, syn;
  slope_e     slope;

  assign raw = {pin_i, rxd_i, txd_i};

  fsl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  fsl_slope_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bat_ok_i (bat_ok_i),
    .vreg_ok_i(vreg_ok_i),
    .pin_s_i  (syn[2]),
    .oe_o     (pin_oe_o),
    .slope_o  (slope)
  );

  fsl_fault_eval #(.MASK_CYC(MASK_CYC)) u_eval (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .txd_s_i(syn[0]),
    .rxd_s_i(syn[1]),
    .therm_i(therm_i),
    .ok_o   (pin_o)
  );

  assign slope_fast_o = (slope == SLOPE_FAST);
endmodule

// File: rtl/fault_slope_ctrl_chk.sv
module fault_slope_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic therm_i,
  input logic bat_ok_i,
  input logic vreg_ok_i,
  input logic pin_o,
  input logic pin_oe_o,
  input logic slope_fast_o
);
  p_no_early_enable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pin_oe_o && !(bat_ok_i && vreg_ok_i)) |=> !pin_oe_o);

  p_enable_on_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pin_oe_o && bat_ok_i && vreg_ok_i) |=> pin_oe_o);

  p_slope_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o && bat_ok_i) |=> ($stable(slope_fast_o) && pin_oe_o));

  p_bat_off_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bat_ok_i |=> (!slope_fast_o && !pin_oe_o));

  p_therm_forces_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm_i |=> !pin_o);
endmodule

bind fault_slope_ctrl fault_slope_ctrl_chk u_chk (.*);

// File: tb/fault_slope_ctrl_test.sv
`timescale 1ns/1ps
module fault_slope_ctrl_test;
  localparam int S = 2;
  localparam int M = 5;

  logic clk = 1'b0;
  logic rst_ni;
  logic txd, rxd, therm, bat_ok, vreg_ok, pin_in;
  logic pin_o, pin_oe, slope_fast;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  always #5 clk = ~clk;

  fault_slope_ctrl #(.SYNC_STAGES(S), .MASK_CYC(M)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .txd_i       (txd),
    .rxd_i       (rxd),
    .therm_i     (therm),
    .bat_ok_i    (bat_ok),
    .vreg_ok_i   (vreg_ok),
    .pin_i       (pin_in),
    .pin_o       (pin_o),
    .pin_oe_o    (pin_oe),
    .slope_fast_o(slope_fast)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_ni = 0; txd = 1; rxd = 1; therm = 0; bat_ok = 0; vreg_ok = 0; pin_in = 0;
    #1;
    chk("R1 reset oe", pin_oe, 1'b0);
    chk("R1 reset slope", slope_fast, 1'b0);
    tick(3);
    @(negedge clk) rst_ni = 1;
    tick(2);
    chk("R1 after reset oe", pin_oe, 1'b0);
    chk("R1 after reset slope", slope_fast, 1'b0);

    // R2: only one of the two flags present
    @(negedge clk) bat_ok = 1;
    tick(10);
    chk("R2 bat only oe", pin_oe, 1'b0);
    chk("R2 bat only slope", slope_fast, 1'b0);
    @(negedge clk) begin bat_ok = 0; vreg_ok = 1; end
    tick(5);
    chk("R2 vreg only oe", pin_oe, 1'b0);

    // R3: pin low selects fast slope
    @(negedge clk) bat_ok = 1;
    tick(1);
    chk("R3 oe on sample edge", pin_oe, 1'b1);
    chk("R3 low pin gives fast", slope_fast, 1'b1);

    // R4: hold through regulator loss and pin change
    @(negedge clk) begin vreg_ok = 0; pin_in = 1; end
    tick(10);
    chk("R4 hold slope", slope_fast, 1'b1);
    chk("R4 hold oe", pin_oe, 1'b1);
    @(negedge clk) vreg_ok = 1;
    tick(5);
    chk("R4 hold after wake", slope_fast, 1'b1);

    // R5: battery off clears, then resample high pin
    @(negedge clk) bat_ok = 0;
    tick(1);
    chk("R5 clear oe", pin_oe, 1'b0);
    chk("R5 clear slope", slope_fast, 1'b0);
    tick(3);
    @(negedge clk) bat_ok = 1;
    tick(1);
    chk("R5 resample oe", pin_oe, 1'b1);
    chk("R3 high pin gives normal", slope_fast, 1'b0);

    // R6/R7: full sweep of txd, rxd, therm
    for (int c = 0; c < 8; c++) begin
      logic t, r, h;
      t = c[0]; r = c[1]; h = c[2];
      @(negedge clk) begin txd = t; rxd = r; therm = h; end
      tick(M + S + 4);
      chk(h ? "R7 sweep thermal" : "R6 sweep compare", pin_o, !h && (t == r));
      chk("R4 oe in sweep", pin_oe, 1'b1);
    end

    // settle to agreement
    @(negedge clk) begin txd = 1; rxd = 1; therm = 0; end
    tick(M + S + 4);
    chk("R6 idle ok", pin_o, 1'b1);

    // R6 latency on rxd change alone
    @(negedge clk) rxd = 0;
    tick(S);
    chk("R6 rxd not early", pin_o, 1'b1);
    tick(1);
    chk("R6 rxd latency", pin_o, 1'b0);
    @(negedge clk) rxd = 1;
    tick(M + S + 4);

    // R7 latency
    @(negedge clk) therm = 1;
    #1;
    chk("R7 not before edge", pin_o, 1'b1);
    tick(1);
    chk("R7 one edge", pin_o, 1'b0);
    @(negedge clk) therm = 0;
    tick(M + S + 4);
    chk("R7 release", pin_o, 1'b1);

    // R8 blanking after a txd edge
    @(negedge clk) txd = 0;
    tick(M + S);
    chk("R8 masked window", pin_o, 1'b1);
    tick(1);
    chk("R8 window end", pin_o, 1'b0);
    @(negedge clk) txd = 1;
    tick(M + S + 4);
    chk("R8 recover", pin_o, 1'b1);

    // R9 restart of the window
    @(negedge clk) txd = 0;
    tick(3);
    @(negedge clk) begin txd = 1; rxd = 0; end
    tick(M + S);
    chk("R9 restarted mask", pin_o, 1'b1);
    tick(1);
    chk("R9 restarted end", pin_o, 1'b0);

    finish_run();
  end
endmodule